// File: doc/BRIEF.md
# Four-Phase Subtract-and-Sleep Instruction Executor

This block runs two single-word instructions of a small 8-bit accumulator core and steps each one through four clock phases, named Q1 to Q4. An instruction takes four clocks. The first instruction is the subtract-with-borrow. It reads one byte from the register file and computes the working register minus that byte minus a borrow. The borrow is the inverse of the current carry flag. The result goes either to the working register or back to the same file location, and five status flags are updated. The second instruction is sleep entry. It clears the watchdog and its postscaler, sets the time-out bit, clears the power-down bit, and raises a sleep request. The request stays high until a wake-up input arrives.

The phase sequencer has five states: PH_Q1 (decode), PH_Q2 (operand read), PH_Q3 (process), PH_Q4 (write-back or sleep entry) and PH_SLEEP (halted). The transitions are:
- Q1→Q2, Q2→Q3 and Q3→Q4 always.
- Q4→Q1 for any instruction that is not sleep.
- Q4→SLEEP for the sleep opcode.
- SLEEP→Q1 on the clock edge where `wake` is high.

The instruction word is captured at the end of Q1. The surrounding core supplies instructions and owns the register file, which answers a read in the same cycle it is asked.

Top module: `qx_exec`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, the following hold: `w_out` is 0, `status` is 0, `to_flag` and `pd_flag` are 1, `sleep_req` is 0, and the sequencer is in Q1.
- R2: Every instruction takes exactly four clocks (Q1, Q2, Q3, Q4). `instr` is sampled on the clock edge that ends Q1, and the next instruction is sampled four clocks later.
- R3: An instruction with `instr[15:10]` = 6'b010101 is the subtract. Its result is (W − F − (1 − C)) mod 256, where F is the byte read and C is `status[0]`.
- R4: The subtract writes the following flags on the edge that ends Q4. The layout is `status` = {N, OV, Z, DC, C} with C at bit 0.
  - C = 1 when there is no borrow out of bit 7.
  - DC = 1 when there is no borrow out of bit 3.
  - Z = 1 when the result is zero.
  - N = result bit 7.
  - OV = 1 on two's-complement overflow.
- R5: Destination bit `instr[9]` selects where the result goes.
  - When it is 0, the result goes to W and the file is not written.
  - When it is 1, `rf_we` is high for exactly the Q4 cycle, with `rf_wdata` = result and `rf_addr` = `instr[7:0]`, and W keeps its value.
- R6: During Q2 of a subtract, `rf_re` is high, `rf_addr` = `instr[7:0]` and `rf_bank_sel` = `instr[8]`. A value of 0 selects the access bank and 1 selects the bank register.
- R7: The sleep opcode is 16'h0003. During its Q3, `wdt_clr` and `wdt_post_clr` are each high for one cycle. From Q4 onward, `to_flag` = 1 and `pd_flag` = 0. W and `status` do not change.
- R8: `sleep_req` goes high in Q4 of the sleep instruction and stays high until the wake-up edge.
- R9: While asleep, `instr` is ignored. W, `status` and the register file do not change.
- R10: When `wake` is high while asleep, the sequencer is in Q1 on the next cycle and `sleep_req` is 0. `to_flag` is cleared if `wake_by_wdt` is high and kept otherwise. `pd_flag` stays 0.
- R11: Any other opcode takes four clocks. It does not write the file and leaves W and `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one phase per cycle |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word, sampled at the end of Q1 |
| rf_addr | output | 8 | Register file byte address |
| rf_bank_sel | output | 1 | 0 = access bank, 1 = bank register selects the bank |
| rf_re | output | 1 | Register file read strobe (Q2) |
| rf_rdata | input | 8 | Register file read data, same cycle |
| rf_we | output | 1 | Register file write strobe (Q4) |
| rf_wdata | output | 8 | Register file write data |
| w_out | output | 8 | Working register |
| status | output | 5 | {N, OV, Z, DC, C} |
| to_flag | output | 1 | Time-out status bit |
| pd_flag | output | 1 | Power-down status bit |
| wdt_clr | output | 1 | Watchdog counter clear strobe |
| wdt_post_clr | output | 1 | Watchdog postscaler clear strobe |
| sleep_req | output | 1 | Stop-oscillator request |
| wake | input | 1 | Wake-up event |
| wake_by_wdt | input | 1 | Wake-up was caused by the watchdog |

## Verification
The assertions make these assumptions about the inputs:
- `rf_rdata` is valid in the same Q2 cycle as `rf_re`.
- `instr` is stable across the edge that ends Q1.
- `wake` is a single-cycle event that only matters while the block is asleep.
- `wake_by_wdt` is only meaningful together with `wake`.

The bench keeps to these assumptions:
- It changes inputs only on falling edges, and it loads each instruction at the start of Q1.
- Its register file model answers reads combinationally.
- It pulses `wake` for one cycle, and only once `sleep_req` shows the block is halted.
- The opcodes it drives during sleep are deliberately subtracts, to show they are ignored.

// File: rtl/qx_pkg.sv
package qx_pkg;

    // Instruction phases plus the halted state
    typedef enum logic [2:0] {
        PH_Q1    = 3'd0,
        PH_Q2    = 3'd1,
        PH_Q3    = 3'd2,
        PH_Q4    = 3'd3,
        PH_SLEEP = 3'd4
    } qx_phase_e;

    // Status flags, C at bit 0
    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } qx_flags_t;

    localparam int          QX_IW       = 16;
    localparam int          QX_AW       = 8;
    localparam logic [5:0]  QX_SUB_TOP  = 6'b010101;
    localparam logic [15:0] QX_SLEEP_OP = 16'h0003;
    localparam int          QX_DEST_BIT = 9;
    localparam int          QX_BANK_BIT = 8;

endpackage

// File: rtl/qx_sub_alu.sv
module qx_sub_alu
    import qx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output qx_flags_t     fl
);
    localparam int NW = 4;

    logic [DW:0] full;
    logic [NW:0] nib;
    logic        bw;

    always_comb begin
        bw     = ~cin;
        full   = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, bw};
        nib    = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, bw};
        res    = full[DW-1:0];
        fl.c   = ~full[DW];
        fl.dc  = ~nib[NW];
        fl.z   = (full[DW-1:0] == '0);
        fl.n   = full[DW-1];
        fl.ov  = (a[DW-1] ^ b[DW-1]) & (full[DW-1] ^ a[DW-1]);
    end
endmodule

// File: rtl/qx_sequencer.sv
module qx_sequencer
    import qx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      is_sleep,
    input  logic      wake,
    output qx_phase_e phase
);
    qx_phase_e nxt;

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_Q1;
        else     phase <= nxt;
    end

    always_comb begin
        nxt = PH_Q1;
        unique case (phase)
            PH_Q1:    nxt = PH_Q2;
            PH_Q2:    nxt = PH_Q3;
            PH_Q3:    nxt = PH_Q4;
            PH_Q4:    nxt = is_sleep ? PH_SLEEP : PH_Q1;
            PH_SLEEP: nxt = wake ? PH_Q1 : PH_SLEEP;
            default:  nxt = PH_Q1;
        endcase
    end

    // R2: phases advance one step per clock outside sleep
    a_r2_q1_to_q2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_Q1) |=> (phase == PH_Q2));
    a_r2_q3_to_q4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_Q3) |=> (phase == PH_Q4));
endmodule

// File: rtl/qx_power.sv
module qx_power (
    input  logic clk,
    input  logic rst,
    input  logic sleep_q3,
    input  logic asleep,
    input  logic wake,
    input  logic wake_by_wdt,
    output logic to_flag,
    output logic pd_flag,
    output logic wdt_clr,
    output logic wdt_post_clr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            to_flag <= 1'b1;
            pd_flag <= 1'b1;
        end else if (sleep_q3) begin
            to_flag <= 1'b1;
            pd_flag <= 1'b0;
        end else if (asleep && wake && wake_by_wdt) begin
            to_flag <= 1'b0;
        end
    end

    always_comb begin
        wdt_clr      = sleep_q3;
        wdt_post_clr = sleep_q3;
    end

    // R10: watchdog-caused wake clears TO
    a_r10_wdt_wake: assert property (@(posedge clk) disable iff (rst)
        (asleep && wake && wake_by_wdt) |=> !to_flag);
    // R10: PD stays cleared through wake-up
    a_r10_pd_kept: assert property (@(posedge clk) disable iff (rst)
        (asleep && wake) |=> !pd_flag);
    // R7: the clear strobes last one cycle
    a_r7_clr_single: assert property (@(posedge clk) disable iff (rst)
        wdt_clr |=> !wdt_clr);
endmodule

// File: rtl/qx_exec.sv
module qx_exec
    import qx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [QX_IW-1:0] instr,
    output logic [QX_AW-1:0] rf_addr,
    output logic             rf_bank_sel,
    output logic             rf_re,
    input  logic [DW-1:0]    rf_rdata,
    output logic             rf_we,
    output logic [DW-1:0]    rf_wdata,
    output logic [DW-1:0]    w_out,
    output logic [4:0]       status,
    output logic             to_flag,
    output logic             pd_flag,
    output logic             wdt_clr,
    output logic             wdt_post_clr,
    output logic             sleep_req,
    input  logic             wake,
    input  logic             wake_by_wdt
);
    qx_phase_e      phase;
    logic [QX_IW-1:0] ir;
    logic [DW-1:0]  w_q, opnd_q, res_q, alu_res;
    qx_flags_t      st_q, fl_q, alu_fl;
    logic           is_sub, is_sleep, dest_f;

    assign is_sub   = (ir[15:10] == QX_SUB_TOP);
    assign is_sleep = (ir == QX_SLEEP_OP);
    assign dest_f   = ir[QX_DEST_BIT];

    qx_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .is_sleep (is_sleep),
        .wake     (wake),
        .phase    (phase)
    );

    qx_sub_alu #(.DW(DW)) u_alu (
        .a   (w_q),
        .b   (opnd_q),
        .cin (st_q.c),
        .res (alu_res),
        .fl  (alu_fl)
    );

    qx_power u_pwr (
        .clk          (clk),
        .rst          (rst),
        .sleep_q3     ((phase == PH_Q3) && is_sleep),
        .asleep       (phase == PH_SLEEP),
        .wake         (wake),
        .wake_by_wdt  (wake_by_wdt),
        .to_flag      (to_flag),
        .pd_flag      (pd_flag),
        .wdt_clr      (wdt_clr),
        .wdt_post_clr (wdt_post_clr)
    );

    // Datapath registers, advanced by phase
    always_ff @(posedge clk) begin
        if (rst) begin
            ir     <= '0;
            w_q    <= '0;
            st_q   <= '0;
            opnd_q <= '0;
            res_q  <= '0;
            fl_q   <= '0;
        end else begin
            unique case (phase)
                PH_Q1: ir <= instr;
                PH_Q2: if (is_sub) opnd_q <= rf_rdata;
                PH_Q3: if (is_sub) begin
                    res_q <= alu_res;
                    fl_q  <= alu_fl;
                end
                PH_Q4: if (is_sub) begin
                    st_q <= fl_q;
                    if (!dest_f) w_q <= res_q;
                end
                PH_SLEEP: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rf_addr     = ir[QX_AW-1:0];
        rf_bank_sel = ir[QX_BANK_BIT];
        rf_re       = (phase == PH_Q2) && is_sub;
        rf_we       = (phase == PH_Q4) && is_sub && dest_f;
        rf_wdata    = res_q;
        w_out       = w_q;
        status      = st_q;
        sleep_req   = ((phase == PH_Q4) && is_sleep) || (phase == PH_SLEEP);
    end

    // R5: write strobe lasts one cycle
    a_r5_we_single: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we);
    // R6: each write-back follows its own Q2 read two cycles earlier
    a_r6_read_before_write: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> $past(rf_re, 2));
    // R7: TO set and PD cleared by the time sleep is requested
    a_r7_flags_before_sleep: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_req) |-> (to_flag && !pd_flag));
    // R9: nothing moves while halted
    a_r9_sleep_hold: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_SLEEP) && !wake) |=> ($stable(w_q) && $stable(st_q) && !rf_we));
    // R8: request held until wake
    a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && (phase == PH_SLEEP) && !wake) |=> sleep_req);
endmodule

// File: tb/qx_exec_test.sv
`timescale 1ns/1ps
module qx_exec_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = 16'h0000;
    logic [7:0]  rf_addr, rf_wdata, w_out, rf_rdata;
    logic        rf_bank_sel, rf_re, rf_we;
    logic [4:0]  status;
    logic        to_flag, pd_flag, wdt_clr, wdt_post_clr, sleep_req;
    logic        wake = 1'b0;
    logic        wake_by_wdt = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [7:0] mem [256];

    always #10 clk = ~clk;

    assign rf_rdata = mem[rf_addr];
    always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

    qx_exec uut (
        .clk(clk), .rst(rst), .instr(instr),
        .rf_addr(rf_addr), .rf_bank_sel(rf_bank_sel), .rf_re(rf_re),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .w_out(w_out), .status(status), .to_flag(to_flag), .pd_flag(pd_flag),
        .wdt_clr(wdt_clr), .wdt_post_clr(wdt_post_clr), .sleep_req(sleep_req),
        .wake(wake), .wake_by_wdt(wake_by_wdt)
    );

    // {w, f, result, flags{n,ov,z,dc,c}, carry_in, d, a}
    localparam logic [31:0] VEC [0:6] = '{
        {8'h02, 8'h03, 8'hFF, 5'b10000, 1'b1, 1'b1, 1'b0},
        {8'h05, 8'h02, 8'h03, 5'b00011, 1'b1, 1'b0, 1'b1},
        {8'h02, 8'h01, 8'h00, 5'b00111, 1'b0, 1'b1, 1'b0},
        {8'h80, 8'h01, 8'h7F, 5'b01001, 1'b1, 1'b0, 1'b0},
        {8'h7F, 8'hFF, 8'h80, 5'b11010, 1'b1, 1'b1, 1'b1},
        {8'h10, 8'h0F, 8'h00, 5'b00101, 1'b0, 1'b0, 1'b1},
        {8'h00, 8'hFF, 8'h00, 5'b00100, 1'b0, 1'b1, 1'b0}
    };

    logic       c_re, c_bank, c_wdt, c_post, c_we, c_sreq;
    logic [7:0] c_addr, c_wd;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Starts and ends on a falling edge inside Q1
    task automatic run_instr(input logic [15:0] op);
        instr = op;
        @(posedge clk);
        @(negedge clk); c_re = rf_re; c_addr = rf_addr; c_bank = rf_bank_sel;
        @(posedge clk);
        @(negedge clk); c_wdt = wdt_clr; c_post = wdt_post_clr;
        @(posedge clk);
        @(negedge clk); c_we = rf_we; c_wd = rf_wdata; c_sreq = sleep_req;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] sub_op(input logic d, input logic a, input logic [7:0] ad);
        return {6'b010101, d, a, ad};
    endfunction

    task automatic set_w(input logic [7:0] target);
        mem[8'hE0] = w_out - target - {7'd0, ~status[0]};
        run_instr(sub_op(1'b0, 1'b0, 8'hE0));
    endtask

    task automatic set_c(input logic cv);
        mem[8'hE1] = cv ? 8'h00 : 8'hFF;
        run_instr(sub_op(1'b1, 1'b0, 8'hE1));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 w", w_out, 8'h00);
        chk("R1 status", status, 5'h00);
        chk("R1 to/pd", {to_flag, pd_flag}, 2'b11);
        chk("R1 sleep_req", sleep_req, 1'b0);
        rst = 1'b0;
        chk("R1 held after release", {w_out, status, sleep_req}, 14'h0);

        // Vector table: R3 R4 R5 R6
        for (int i = 0; i < 7; i++) begin
            logic [7:0] vw, vf, vr, ad;
            logic [4:0] vfl;
            logic vc, vd, va;
            {vw, vf, vr, vfl, vc, vd, va} = VEC[i];
            ad = 8'h20 + 8'(i);
            set_w(vw);
            chk("R3 setup w", w_out, vw);
            set_c(vc);
            chk("R4 setup c", status[0], vc);
            mem[ad] = vf;
            run_instr(sub_op(vd, va, ad));
            chk("R6 read strobe", {c_re, c_addr, c_bank}, {1'b1, ad, va});
            chk("R4 flags", status, vfl);
            if (vd) begin
                chk("R5 write strobe", {c_we, c_wd}, {1'b1, vr});
                chk("R3 file result", mem[ad], vr);
                chk("R5 w kept", w_out, vw);
            end else begin
                chk("R5 no write", c_we, 1'b0);
                chk("R3 w result", w_out, vr);
                chk("R5 file kept", mem[ad], vf);
            end
        end

        // R11 unknown opcode
        begin
            logic [7:0] w0; logic [4:0] s0;
            w0 = w_out; s0 = status;
            run_instr(16'h1234);
            chk("R11 no write", {c_we, c_re}, 2'b00);
            chk("R11 state kept", {w_out, status}, {w0, s0});
        end

        // R2 timing: back-to-back instructions land four clocks apart
        set_w(8'h40);
        set_c(1'b1);
        mem[8'h30] = 8'h01;
        run_instr(sub_op(1'b0, 1'b0, 8'h30));
        chk("R2 first", w_out, 8'h3F);
        run_instr(sub_op(1'b0, 1'b0, 8'h30));
        chk("R2 second", w_out, 8'h3E);

        // R7 R8 first sleep
        begin
            logic [7:0] w0; logic [4:0] s0;
            w0 = w_out; s0 = status;
            run_instr(16'h0003);
            chk("R7 clear strobes", {c_wdt, c_post}, 2'b11);
            chk("R8 req in Q4", c_sreq, 1'b1);
            chk("R7 to/pd", {to_flag, pd_flag}, 2'b10);
            chk("R7 state kept", {w_out, status}, {w0, s0});
            // R9 instr ignored while asleep
            mem[8'h31] = 8'h11;
            instr = sub_op(1'b1, 1'b0, 8'h31);
            repeat (10) @(negedge clk);
            chk("R9 w/status kept", {w_out, status}, {w0, s0});
            chk("R9 file kept", mem[8'h31], 8'h11);
            chk("R8 req held", sleep_req, 1'b1);
            instr = 16'h0000;
            // R10 watchdog wake
            wake = 1'b1; wake_by_wdt = 1'b1;
            @(posedge clk);
            @(negedge clk);
            wake = 1'b0; wake_by_wdt = 1'b0;
            chk("R10 wdt wake to/pd", {to_flag, pd_flag}, 2'b00);
            chk("R10 req dropped", sleep_req, 1'b0);
            run_instr(sub_op(1'b0, 1'b0, 8'h30));
            chk("R10 resumes at Q1", w_out, 8'h3D);
        end

        // R7 TO set again, then R10 non-watchdog wake keeps TO
        run_instr(16'h0003);
        chk("R7 to set", {to_flag, pd_flag}, 2'b10);
        @(negedge clk);
        wake = 1'b1; wake_by_wdt = 1'b0;
        @(posedge clk);
        @(negedge clk);
        wake = 1'b0;
        chk("R10 other wake keeps to", {to_flag, pd_flag, sleep_req}, 3'b100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule